// File: doc/BRIEF.md
# Paging Translation Lookaside Buffer

This block turns 32-bit linear addresses into 32-bit physical addresses for 4 KB pages. It keeps a small, fully associative cache of recent page translations. With the default 32 entries it covers 128 KB of paged memory. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits are the page number, and they are swapped for a frame number taken from a matching entry. When the paging-enable input is low, the block does no lookup at all and returns the linear address as the physical address.

Lookup requests arrive on a valid/ready port. A request is accepted in a cycle where both `req_valid` and `req_ready` are high. The answer appears on `rsp_valid` exactly one cycle later and has no ready of its own, so the consumer must take it in that cycle. On a miss the answer carries `rsp_hit` low, and the block raises `miss_req` with the missing page number. It then holds `req_ready` low, and accepts no new request, until a fill for that same page number arrives.

The fill port stands in for an external table walker and is always accepted, except in a cycle where `flush` is high. A fill with its present bit set is stored. It overwrites an entry that already holds the same page, or else takes the lowest free slot, or else replaces the slot pointed to by a round-robin pointer. A fill with its present bit clear is not stored. Instead it raises a one-cycle fault pulse, presents exception vector 14, and loads a read-only fault-address register. `flush` empties the whole buffer in one cycle, as a reload of the page-directory base would.

Top module: `paging_tlb`

## Requirements
- R1: After reset the buffer holds no valid entries, and `rsp_valid`, `miss_req` and `fault_pulse` are 0, `req_ready` is 1 and `fault_laddr` is 0.
- R2: When `paging_en` is 0, an accepted request produces, one cycle later, `rsp_valid`=1, `rsp_hit`=1 and `rsp_paddr` equal to `req_laddr`, with no miss raised even when the buffer is empty.
- R3: When `paging_en` is 1 and the page number `req_laddr[31:12]` matches a valid entry, the response one cycle after acceptance has `rsp_hit`=1 and `rsp_paddr` = {stored frame, `req_laddr[11:0]`}.
- R4: When `paging_en` is 1 and no entry matches, the response has `rsp_hit`=0, and in the same cycle `miss_req` rises with `miss_page` = `req_laddr[31:12]`. From then on `req_ready` stays 0 and `miss_req` stays 1 until a fill whose `fill_page` equals `miss_page` is taken. Fills for other pages do not clear it.
- R5: A taken fill with `fill_present`=1 is stored and later lookups of that page hit with `fill_frame`. A fill for a page already held overwrites that entry in place, so a later lookup returns exactly the new frame.
- R6: A new page goes to the lowest-index invalid slot while one exists. When all slots are valid, it replaces the slot at a round-robin pointer that starts at 0, advances by one after each replacement, and wraps after the last slot.
- R7: A taken fill with `fill_present`=0 is not stored. It raises `fault_pulse` for one cycle, one cycle after the fill, with `fault_vector`=14. `fault_laddr` is loaded with the full pending linear address when the fill matches the pending miss, or with {`fill_page`, 12'h000} otherwise, and it holds that value until the next fault.
- R8: `flush` invalidates every entry in one cycle and returns the round-robin pointer to 0. A fill in the same cycle is ignored: nothing is stored, no fault is raised and no pending miss is cleared. A pending miss stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | 1: translate through the buffer; 0: physical address = linear address |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Request can be accepted (low while a miss is pending) |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Translation available in `rsp_paddr` |
| rsp_paddr | output | 32 | Physical address |
| miss_req | output | 1 | A miss is waiting for a fill |
| miss_page | output | 20 | Page number of the pending miss |
| fill_valid | input | 1 | Fill strobe |
| fill_page | input | 20 | Linear page number of the fill |
| fill_frame | input | 20 | Physical frame number of the fill |
| fill_present | input | 1 | 1: page present, store it; 0: page fault |
| flush | input | 1 | Invalidate all entries |
| fault_pulse | output | 1 | One-cycle page-fault pulse |
| fault_vector | output | 8 | Exception number (14) while `fault_pulse` is high, else 0 |
| fault_laddr | output | 32 | Linear address of the last fault |

## Verification
The bench builds the block with `ENTRIES`=4 and leaves the address widths at 32 bits with a 12-bit offset. With four slots, filling the buffer, replacing entries round-robin and wrapping the pointer back to slot 0 all take only a handful of fills, and the bench checks each victim by looking up which pages survive. Pending misses are released with non-present fills, so probing a missing page does not disturb the slots under test. The in-place update is checked with two frame values whose bitwise OR differs from either one, so a duplicate entry shows up in the returned address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PAGE_OFF_W = 12;

  typedef enum logic [1:0] {
    VSRC_SAME = 2'd0,
    VSRC_FREE = 2'd1,
    VSRC_RR   = 2'd2
  } victim_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PFN_W-1:0]   wr_pfn_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic [ENTRIES-1:0] lk_match_o,
  output logic [PFN_W-1:0]   lk_pfn_o,
  input  logic [VPN_W-1:0]   fl_vpn_i,
  output logic [ENTRIES-1:0] fl_match_o,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        vpn_q[e]   <= '0;
        pfn_q[e]   <= '0;
      end else if (flush_i) begin
        valid_q[e] <= 1'b0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        vpn_q[e]   <= wr_vpn_i;
        pfn_q[e]   <= wr_pfn_i;
      end
    end

    assign lk_match_o[e] = valid_q[e] && (vpn_q[e] == lk_vpn_i);
    assign fl_match_o[e] = valid_q[e] && (vpn_q[e] == fl_vpn_i);
  end

  always_comb begin
    lk_pfn_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match_o[e]) lk_pfn_o = lk_pfn_o | pfn_q[e];
    end
  end

  assign valid_o = valid_q;

  // R5: a page is never held twice, so at most one slot matches
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_o));

  // R8: a flush leaves no valid slot behind
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> (valid_q == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               alloc_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] same_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_same;
  logic             any_free;
  victim_src_e      src;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_i[i])   same_idx = IDX_W'(i);
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_same = |same_i;
  assign any_free = ~&valid_i;

  always_comb begin
    if (any_same)      src = VSRC_SAME;
    else if (any_free) src = VSRC_FREE;
    else               src = VSRC_RR;
  end

  always_comb begin
    unique case (src)
      VSRC_SAME: idx_o = same_idx;
      VSRC_FREE: idx_o = free_idx;
      default:   idx_o = rr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      rr_q <= '0;
    end else if (alloc_i && (src == VSRC_RR)) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // R6: while a slot is free and the page is new, the chosen slot is an empty one
  p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && any_free && !any_same) |-> !valid_i[idx_o]);

  // R6: the pointer never leaves the slot range
  p_rr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= LAST);
endmodule

// File: rtl/tlb_miss_ctl.sv
module tlb_miss_ctl #(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned VPN_W = LA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [LA_W-1:0]  set_laddr_i,
  input  logic             fill_take_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic             fill_present_i,
  output logic             pend_o,
  output logic [VPN_W-1:0] pend_vpn_o,
  output logic             fault_o,
  output logic [LA_W-1:0]  fault_laddr_o
);
  logic            pend_q;
  logic [LA_W-1:0] pend_laddr_q;
  logic            resolve;
  logic            fault_q;
  logic [LA_W-1:0] fault_laddr_q;

  assign pend_vpn_o = pend_laddr_q[LA_W-1:OFF_W];
  assign resolve    = fill_take_i && pend_q && (fill_vpn_i == pend_vpn_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_laddr_q <= '0;
    end else if (set_i) begin
      pend_q       <= 1'b1;
      pend_laddr_q <= set_laddr_i;
    end else if (resolve) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q       <= 1'b0;
      fault_laddr_q <= '0;
    end else begin
      fault_q <= fill_take_i && !fill_present_i;
      if (fill_take_i && !fill_present_i) begin
        fault_laddr_q <= resolve ? pend_laddr_q : {fill_vpn_i, {OFF_W{1'b0}}};
      end
    end
  end

  assign pend_o        = pend_q;
  assign fault_o       = fault_q;
  assign fault_laddr_o = fault_laddr_q;

  // R4: a pending miss survives any cycle without a fill for its own page
  p_miss_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(fill_take_i && fill_vpn_i == pend_vpn_o)) |=> pend_q);

  // R7: every fault pulse comes from a taken non-present fill
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $past(fill_take_i && !fill_present_i));
endmodule

// File: rtl/paging_tlb.sv
module paging_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES   = 32,
  parameter int unsigned LA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 14,
  localparam int unsigned OFF_W    = PAGE_OFF_W,
  localparam int unsigned VPN_W    = LA_W - OFF_W,
  localparam int unsigned PFN_W    = PA_W - OFF_W,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             paging_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_page,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_page,
  input  logic [PFN_W-1:0] fill_frame,
  input  logic             fill_present,
  input  logic             flush,
  output logic             fault_pulse,
  output logic [VEC_W-1:0] fault_vector,
  output logic [LA_W-1:0]  fault_laddr
);
  logic               req_fire;
  logic               fill_take;
  logic               fill_store;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   lk_pfn;
  logic [IDX_W-1:0]   wr_idx;
  logic               lk_hit;
  logic               miss_set;
  logic               pend;
  logic               rsp_valid_q;
  logic               rsp_hit_q;
  logic [PA_W-1:0]    rsp_paddr_q;

  assign req_ready  = !pend;
  assign req_fire   = req_valid && req_ready;
  assign fill_take  = fill_valid && !flush;
  assign fill_store = fill_take && fill_present;
  assign lk_hit     = |lk_match;
  assign miss_set   = req_fire && paging_en && !lk_hit;

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .wr_en_i    (fill_store),
    .wr_idx_i   (wr_idx),
    .wr_vpn_i   (fill_page),
    .wr_pfn_i   (fill_frame),
    .lk_vpn_i   (req_laddr[LA_W-1:OFF_W]),
    .lk_match_o (lk_match),
    .lk_pfn_o   (lk_pfn),
    .fl_vpn_i   (fill_page),
    .fl_match_o (fl_match),
    .valid_o    (valid_vec)
  );

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .alloc_i (fill_store),
    .valid_i (valid_vec),
    .same_i  (fl_match),
    .idx_o   (wr_idx)
  );

  tlb_miss_ctl #(
    .LA_W  (LA_W),
    .OFF_W (OFF_W)
  ) u_miss (
    .clk            (clk),
    .rst_n          (rst_n),
    .set_i          (miss_set),
    .set_laddr_i    (req_laddr),
    .fill_take_i    (fill_take),
    .fill_vpn_i     (fill_page),
    .fill_present_i (fill_present),
    .pend_o         (pend),
    .pend_vpn_o     (miss_page),
    .fault_o        (fault_pulse),
    .fault_laddr_o  (fault_laddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= req_fire;
      if (req_fire) begin
        rsp_hit_q <= !paging_en || lk_hit;
        if (!paging_en)  rsp_paddr_q <= PA_W'(req_laddr);
        else if (lk_hit) rsp_paddr_q <= {lk_pfn, req_laddr[OFF_W-1:0]};
        else             rsp_paddr_q <= '0;
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_hit      = rsp_hit_q;
  assign rsp_paddr    = rsp_paddr_q;
  assign miss_req     = pend;
  assign fault_vector = fault_pulse ? VEC_W'(FAULT_VEC) : '0;

  // R3: a response only follows an offered request
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R3: the page offset passes through on every translated answer
  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0])));

  // R2: with paging off the answer is the linear address itself
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!paging_en)) |-> (rsp_hit && rsp_paddr == PA_W'($past(req_laddr))));

  // R4: a miss answer comes with a raised miss request
  p_miss_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> miss_req);
endmodule

// File: tb/sim_paging_tlb.sv
`timescale 1ns/1ps
module sim_paging_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;
  logic        miss_req;
  logic [19:0] miss_page;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_page = '0;
  logic [19:0] fill_frame = '0;
  logic        fill_present = 1'b0;
  logic        flush = 1'b0;
  logic        fault_pulse;
  logic [7:0]  fault_vector;
  logic [31:0] fault_laddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paging_tlb #(.ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .miss_req(miss_req), .miss_page(miss_page),
    .fill_valid(fill_valid), .fill_page(fill_page), .fill_frame(fill_frame),
    .fill_present(fill_present), .flush(flush),
    .fault_pulse(fault_pulse), .fault_vector(fault_vector), .fault_laddr(fault_laddr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  function automatic logic [19:0] frame_of(input logic [19:0] pg);
    return pg ^ 20'h8_0C30;
  endfunction

  // one request; response is checked at the negedge after the capturing edge
  task automatic lookup(input logic [31:0] la, input bit exp_hit,
                        input logic [31:0] exp_pa, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    eq(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    eq(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, exp_hit});
    if (exp_hit) eq(req, "rsp_paddr", rsp_paddr, exp_pa);
    eq(req, "miss_req", {31'd0, miss_req}, {31'd0, !exp_hit});
    if (!exp_hit) begin
      eq(req, "miss_page", {12'd0, miss_page}, {12'd0, la[31:12]});
      eq(req, "req_ready low", {31'd0, req_ready}, 32'd0);
    end
  endtask

  task automatic fill(input logic [19:0] pg, input logic [19:0] fr, input bit pres,
                      input bit with_flush);
    @(negedge clk);
    fill_valid   = 1'b1;
    fill_page    = pg;
    fill_frame   = fr;
    fill_present = pres;
    flush        = with_flush;
    @(negedge clk);
    fill_valid = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // lookup expected to miss, then release with a non-present fill (nothing stored)
  task automatic probe_miss(input logic [31:0] la, input string req);
    lookup(la, 1'b0, 32'd0, req);
    fill(la[31:12], 20'd0, 1'b0, 1'b0);
    eq(req, "miss released", {31'd0, miss_req}, 32'd0);
    eq(req, "fault addr on release", fault_laddr, la);
  endtask

  task automatic t_reset();
    @(negedge clk);
    eq("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    eq("R1", "miss_req", {31'd0, miss_req}, 32'd0);
    eq("R1", "fault_pulse", {31'd0, fault_pulse}, 32'd0);
    eq("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    eq("R1", "fault_laddr", fault_laddr, 32'd0);
  endtask

  task automatic t_bypass();
    paging_en = 1'b0;
    lookup(32'h1234_5678, 1'b1, 32'h1234_5678, "R2");
    lookup(32'hFFFF_F001, 1'b1, 32'hFFFF_F001, "R2");
    paging_en = 1'b1;
    // R1: the empty buffer misses once paging is on
    probe_miss(32'h1234_5678, "R1");
  endtask

  task automatic t_fill_hit();
    fill(20'h12345, 20'h00ABC, 1'b1, 1'b0);
    eq("R5", "no fault on present fill", {31'd0, fault_pulse}, 32'd0);
    lookup(32'h1234_59F0, 1'b1, 32'h00AB_C9F0, "R3");
    lookup(32'h1234_5000, 1'b1, 32'h00AB_C000, "R3");
  endtask

  task automatic t_miss();
    lookup(32'h0BEE_F123, 1'b0, 32'd0, "R4");
    fill(20'h00111, 20'h00222, 1'b1, 1'b0);
    eq("R4", "other-page fill keeps miss", {31'd0, miss_req}, 32'd1);
    eq("R4", "ready still low", {31'd0, req_ready}, 32'd0);
    fill(20'h0BEEF, 20'h00777, 1'b1, 1'b0);
    eq("R4", "matching fill clears miss", {31'd0, miss_req}, 32'd0);
    eq("R4", "ready back", {31'd0, req_ready}, 32'd1);
    lookup(32'h0BEE_F123, 1'b1, 32'h0077_7123, "R4");
    lookup(32'h0011_1ABC, 1'b1, 32'h0022_2ABC, "R5");
  endtask

  task automatic t_fault();
    lookup(32'h5555_5A5C, 1'b0, 32'd0, "R7");
    fill(20'h55555, 20'h00001, 1'b0, 1'b0);
    eq("R7", "fault_pulse", {31'd0, fault_pulse}, 32'd1);
    eq("R7", "fault_vector", {24'd0, fault_vector}, 32'd14);
    eq("R7", "fault_laddr pending", fault_laddr, 32'h5555_5A5C);
    eq("R7", "miss cleared", {31'd0, miss_req}, 32'd0);
    @(negedge clk);
    eq("R7", "pulse one cycle", {31'd0, fault_pulse}, 32'd0);
    eq("R7", "vector idle", {24'd0, fault_vector}, 32'd0);
    eq("R7", "fault_laddr held", fault_laddr, 32'h5555_5A5C);
    probe_miss(32'h5555_5004, "R7");
    fill(20'h00042, 20'h00000, 1'b0, 1'b0);
    eq("R7", "unsolicited fault pulse", {31'd0, fault_pulse}, 32'd1);
    eq("R7", "unsolicited fault addr", fault_laddr, 32'h0004_2000);
  endtask

  task automatic t_flush();
    do_flush();
    probe_miss(32'h1234_5000, "R8");
    probe_miss(32'h0BEE_F000, "R8");
    lookup(32'h0ABC_D010, 1'b0, 32'd0, "R8");
    fill(20'h0ABCD, 20'h00321, 1'b1, 1'b1);
    eq("R8", "miss survives flush", {31'd0, miss_req}, 32'd1);
    eq("R8", "no fault from dropped fill", {31'd0, fault_pulse}, 32'd0);
    fill(20'h0ABCD, 20'h00000, 1'b0, 1'b0);
    eq("R8", "miss released", {31'd0, miss_req}, 32'd0);
    probe_miss(32'h0ABC_D010, "R8");
  endtask

  task automatic t_update();
    do_flush();
    fill(20'h00A00, 20'h00F0F, 1'b1, 1'b0);
    fill(20'h00A00, 20'h0A0A0, 1'b1, 1'b0);
    lookup(32'h00A0_0044, 1'b1, 32'h0A0A_0044, "R5");
  endtask

  task automatic t_round_robin();
    logic [19:0] p [9];
    for (int i = 0; i < 9; i++) p[i] = 20'h20000 + 20'(i * 16'h0101);
    do_flush();
    for (int i = 0; i < 4; i++) fill(p[i], frame_of(p[i]), 1'b1, 1'b0);
    for (int i = 0; i < 4; i++)
      lookup({p[i], 12'h0A5}, 1'b1, {frame_of(p[i]), 12'h0A5}, "R6");
    fill(p[4], frame_of(p[4]), 1'b1, 1'b0);          // replaces slot 0
    probe_miss({p[0], 12'h000}, "R6");
    lookup({p[1], 12'h001}, 1'b1, {frame_of(p[1]), 12'h001}, "R6");
    fill(p[5], frame_of(p[5]), 1'b1, 1'b0);          // slot 1
    fill(p[6], frame_of(p[6]), 1'b1, 1'b0);          // slot 2
    fill(p[7], frame_of(p[7]), 1'b1, 1'b0);          // slot 3
    fill(p[8], frame_of(p[8]), 1'b1, 1'b0);          // wraps to slot 0
    probe_miss({p[4], 12'h000}, "R6");
    lookup({p[5], 12'h777}, 1'b1, {frame_of(p[5]), 12'h777}, "R6");
    lookup({p[8], 12'h777}, 1'b1, {frame_of(p[8]), 12'h777}, "R6");
    // pointer now at 1; a flush must return it to 0
    do_flush();
    for (int i = 0; i < 5; i++) fill(p[i], frame_of(p[i]), 1'b1, 1'b0);
    probe_miss({p[0], 12'h000}, "R8");
    lookup({p[1], 12'h010}, 1'b1, {frame_of(p[1]), 12'h010}, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_fill_hit();
    t_miss();
    t_fault();
    t_flush();
    t_update();
    t_round_robin();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule